// File: doc/BRIEF.md
# Double-Buffered Windowed Frame-Buffer Address Generator

This block produces the stream of 32-bit word addresses that a display fetch engine reads, scanning a rectangular window inside a frame buffer that can be wider and taller than the visible screen. Each window line starts at a line pointer. The line pointer begins at a panel base address and moves forward by a programmable byte increment for every new line. Inside a line, addresses step by 4 bytes. In dual-panel mode a second, lower panel is scanned too: for every line, the lower panel's words follow the upper panel's words. The first word of each line carries a pixel offset that tells the pixel unpacker where the first visible pixel lies within that word.

The host never changes the live bases directly. It writes shadow copies of the upper and lower base, then raises a validate strobe. At the next end of frame both shadows move into the active bases together and the pending flag clears. Without validation the old bases stay in use, so the displayed buffer and the buffer being redrawn swap without tearing. The window geometry (words per line, lines per frame, line increment, pixel offset, panel mode) is sampled once per frame, at frame start. `rd_addr` always shows the address about to be fetched, so the host can use it as the current frame pointer.

The scanner has three states. LOAD commits the bases and latches the geometry. UPPER issues upper-panel words. LOWER issues lower-panel words. The transitions are:
- LOAD→UPPER, always after one cycle.
- UPPER→LOWER, at the end of an upper line in dual mode.
- UPPER→UPPER, at the end of a line that is not the last one in single mode.
- LOWER→UPPER, at the end of a line pair that is not the last one.
- UPPER→LOAD or LOWER→LOAD, when the last word of the frame is accepted.

Top module: `fb_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `rd_valid`, `frame_eof` and `upd_pending` are 0. The active bases after reset are 0.
- R2: Within a line of a panel, word i has the address line_start + 4*i, for i from 0 to `cfg_words_m1`. Bases and line increment are used with their two low bits forced to zero.
- R3: Line k of a panel, for k from 0 to `cfg_lines_m1`, starts at panel_base + k*`cfg_stride`. The upper and lower panels keep separate line pointers and share one increment.
- R4: When `cfg_dual`=1, each line is issued as all upper words (`rd_lower`=0) followed by all lower words (`rd_lower`=1). When `cfg_dual`=0 only upper words are issued.
- R5: `rd_line_first` is 1 exactly on the first word of each panel line. `rd_pix_off` equals the frame's pixel offset on that word and 0 on every other word.
- R6: While `rd_valid`=1 and `rd_ready`=0, the next cycle again has `rd_valid`=1 and the same `rd_addr`.
- R7: Shadow base writes that are not validated do not change the addresses of any later frame.
- R8: A validated pair of shadows becomes active together at the next end of frame, and `upd_pending` returns to 0.
- R9: `frame_eof` is a one-cycle pulse in the cycle after the last word of the frame is accepted. In the next cycle `rd_valid`=1, and `rd_addr` is the newly active upper base, marked as a line start.
- R10: A shadow write or validate strobe in the commit cycle (the cycle `frame_eof` is high) is not used by that commit. A validate strobe in that cycle leaves `upd_pending`=1 for the following end of frame.
- R11: The geometry inputs are sampled only in the commit cycle. Changes to them during a frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we_upper | input | 1 | Write strobe for the upper shadow base |
| host_upper_base | input | 32 | Upper shadow base byte address |
| host_we_lower | input | 1 | Write strobe for the lower shadow base |
| host_lower_base | input | 32 | Lower shadow base byte address |
| host_validate | input | 1 | Marks both shadows ready for commit |
| cfg_dual | input | 1 | 1 selects dual-panel scanning |
| cfg_words_m1 | input | 16 | Words per panel line minus one |
| cfg_lines_m1 | input | 16 | Lines per frame minus one |
| cfg_stride | input | 32 | Byte increment between line starts |
| cfg_pix_off | input | 5 | Position of the first pixel in the first word |
| rd_ready | input | 1 | Fetch engine accepts the address |
| rd_valid | output | 1 | Address is valid |
| rd_addr | output | 32 | Word-aligned byte address; also the frame pointer |
| rd_line_first | output | 1 | Address is the first word of a panel line |
| rd_lower | output | 1 | Address belongs to the lower panel |
| rd_pix_off | output | 5 | Pixel offset for a line-start word, else 0 |
| frame_eof | output | 1 | End-of-frame pulse |
| upd_pending | output | 1 | Validated shadows await commit |

## Verification
Commit of the shadows and new host activity can fall in the same cycle: the end-of-frame commit cycle can also carry a shadow write and a validate strobe. The bench drives these strobes exactly in the cycle where it sees `frame_eof` high. This is done once with nothing pending and once with an earlier validation still pending. It then judges by the base addresses of the next two frames and by `upd_pending`: the older shadows must be committed first, and the new strobe must stay pending. Geometry changes are applied in that same cycle, and also in the middle of frames, across a sweep of word counts, line counts and panel modes, with a stalling ready pattern.

// File: rtl/fb_pkg.sv
package fb_pkg;
    typedef enum logic [1:0] {
        S_LOAD  = 2'd0,
        S_UPPER = 2'd1,
        S_LOWER = 2'd2
    } scan_st_t;
endpackage

// File: rtl/fb_shadow.sv
module fb_shadow #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_upper,
    input  logic [AW-1:0] wdata_upper,
    input  logic          we_lower,
    input  logic [AW-1:0] wdata_lower,
    input  logic          upd_set,
    input  logic          commit,
    output logic [AW-1:0] base_upper,
    output logic [AW-1:0] base_lower,
    output logic [AW-1:0] load_upper,
    output logic [AW-1:0] load_lower,
    output logic          upd_pending
);
    logic [AW-1:0] sh_upper, sh_lower;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_upper    <= '0;
            sh_lower    <= '0;
            base_upper  <= '0;
            base_lower  <= '0;
            upd_pending <= 1'b0;
        end else begin
            if (we_upper) sh_upper <= {wdata_upper[AW-1:2], 2'b00};
            if (we_lower) sh_lower <= {wdata_lower[AW-1:2], 2'b00};
            if (commit && upd_pending) begin
                base_upper <= sh_upper;
                base_lower <= sh_lower;
            end
            if (upd_set)                     upd_pending <= 1'b1;
            else if (commit)                 upd_pending <= 1'b0;
        end
    end

    // bases the scanner starts from when this cycle commits
    always_comb begin
        load_upper = upd_pending ? sh_upper : base_upper;
        load_lower = upd_pending ? sh_lower : base_lower;
    end

    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(base_upper) && $stable(base_lower))); // R7
    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !upd_set) |=> !upd_pending); // R8
    AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        upd_set |=> upd_pending); // R10
endmodule

// File: rtl/fb_scan.sv
module fb_scan
    import fb_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] load_upper,
    input  logic [AW-1:0] load_lower,
    input  logic          cfg_dual,
    input  logic [CW-1:0] cfg_words_m1,
    input  logic [CW-1:0] cfg_lines_m1,
    input  logic [AW-1:0] cfg_stride,
    input  logic [PW-1:0] cfg_pix_off,
    input  logic          ready,
    output logic          valid,
    output logic [AW-1:0] addr,
    output logic          line_first,
    output logic          lower,
    output logic [PW-1:0] pix_off,
    output logic          eof,
    output logic          commit
);
    localparam logic [AW-1:0] WORD_BYTES = AW'(4);

    scan_st_t      state, state_nxt;
    logic [AW-1:0] cur, up_ln, lo_ln, g_stride;
    logic [CW-1:0] wcnt, lcnt, g_words, g_lines;
    logic [PW-1:0] g_pix;
    logic          g_dual;
    logic          hs, line_end, frame_end;

    always_comb begin
        hs        = (state != S_LOAD) && ready;
        line_end  = hs && (wcnt == g_words);
        frame_end = line_end && (lcnt == g_lines) &&
                    ((state == S_LOWER) || !g_dual);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_LOAD;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_LOAD:  state_nxt = S_UPPER;
            S_UPPER: if (line_end) begin
                         if (g_dual)         state_nxt = S_LOWER;
                         else if (frame_end) state_nxt = S_LOAD;
                     end
            S_LOWER: if (line_end)
                         state_nxt = frame_end ? S_LOAD : S_UPPER;
            default: state_nxt = S_LOAD;
        endcase
    end

    // address datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0; up_ln <= '0; lo_ln <= '0; g_stride <= '0;
            wcnt <= '0; lcnt <= '0; g_words <= '0; g_lines <= '0;
            g_pix <= '0; g_dual <= 1'b0; eof <= 1'b0;
        end else begin
            eof <= frame_end;
            if (state == S_LOAD) begin
                cur      <= load_upper;
                up_ln    <= load_upper;
                lo_ln    <= load_lower;
                wcnt     <= '0;
                lcnt     <= '0;
                g_words  <= cfg_words_m1;
                g_lines  <= cfg_lines_m1;
                g_stride <= {cfg_stride[AW-1:2], 2'b00};
                g_pix    <= cfg_pix_off;
                g_dual   <= cfg_dual;
            end else if (hs) begin
                if (!line_end) begin
                    cur  <= cur + WORD_BYTES;
                    wcnt <= wcnt + 1'b1;
                end else begin
                    wcnt <= '0;
                    if (state == S_UPPER && g_dual) begin
                        cur <= lo_ln;
                    end else begin
                        up_ln <= up_ln + g_stride;
                        lo_ln <= lo_ln + g_stride;
                        cur   <= up_ln + g_stride;
                        lcnt  <= lcnt + 1'b1;
                    end
                end
            end
        end
    end

    // outputs
    always_comb begin
        commit     = (state == S_LOAD);
        valid      = (state != S_LOAD);
        addr       = cur;
        lower      = (state == S_LOWER);
        line_first = valid && (wcnt == '0);
        pix_off    = line_first ? g_pix : '0;
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(addr))); // R6
    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (addr[1:0] == 2'b00)); // R2
    AST_EOF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        eof |=> !eof); // R9
    AST_EOF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        eof |=> (valid && line_first && !lower)); // R9
endmodule

// File: rtl/fb_addr_gen.sv
module fb_addr_gen #(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we_upper,
    input  logic [AW-1:0] host_upper_base,
    input  logic          host_we_lower,
    input  logic [AW-1:0] host_lower_base,
    input  logic          host_validate,
    input  logic          cfg_dual,
    input  logic [CW-1:0] cfg_words_m1,
    input  logic [CW-1:0] cfg_lines_m1,
    input  logic [AW-1:0] cfg_stride,
    input  logic [PW-1:0] cfg_pix_off,
    input  logic          rd_ready,
    output logic          rd_valid,
    output logic [AW-1:0] rd_addr,
    output logic          rd_line_first,
    output logic          rd_lower,
    output logic [PW-1:0] rd_pix_off,
    output logic          frame_eof,
    output logic          upd_pending
);
    logic [AW-1:0] base_upper, base_lower, load_upper, load_lower;
    logic          commit;

    fb_shadow #(.AW(AW)) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_upper    (host_we_upper),
        .wdata_upper (host_upper_base),
        .we_lower    (host_we_lower),
        .wdata_lower (host_lower_base),
        .upd_set     (host_validate),
        .commit      (commit),
        .base_upper  (base_upper),
        .base_lower  (base_lower),
        .load_upper  (load_upper),
        .load_lower  (load_lower),
        .upd_pending (upd_pending)
    );

    fb_scan #(.AW(AW), .CW(CW), .PW(PW)) u_scan (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_upper   (load_upper),
        .load_lower   (load_lower),
        .cfg_dual     (cfg_dual),
        .cfg_words_m1 (cfg_words_m1),
        .cfg_lines_m1 (cfg_lines_m1),
        .cfg_stride   (cfg_stride),
        .cfg_pix_off  (cfg_pix_off),
        .ready        (rd_ready),
        .valid        (rd_valid),
        .addr         (rd_addr),
        .line_first   (rd_line_first),
        .lower        (rd_lower),
        .pix_off      (rd_pix_off),
        .eof          (frame_eof),
        .commit       (commit)
    );

    AST_RESTART_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_eof |=> (rd_addr == base_upper)); // R9
endmodule

// File: tb/fb_addr_gen_tb.sv
`timescale 1ns/1ps
module fb_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_we_upper = 0, host_we_lower = 0, host_validate = 0;
    logic [31:0] host_upper_base = 0, host_lower_base = 0;
    logic        cfg_dual;
    logic [15:0] cfg_words_m1, cfg_lines_m1;
    logic [31:0] cfg_stride;
    logic [4:0]  cfg_pix_off;
    logic        rd_ready = 0;
    logic        rd_valid, rd_line_first, rd_lower, frame_eof, upd_pending;
    logic [31:0] rd_addr;
    logic [4:0]  rd_pix_off;

    int checks = 0;
    int errors = 0;
    logic [7:0] lfsr = 8'hA5;

    always #5 clk = ~clk;

    fb_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_we_upper(host_we_upper), .host_upper_base(host_upper_base),
        .host_we_lower(host_we_lower), .host_lower_base(host_lower_base),
        .host_validate(host_validate),
        .cfg_dual(cfg_dual), .cfg_words_m1(cfg_words_m1),
        .cfg_lines_m1(cfg_lines_m1), .cfg_stride(cfg_stride),
        .cfg_pix_off(cfg_pix_off), .rd_ready(rd_ready),
        .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_line_first(rd_line_first), .rd_lower(rd_lower),
        .rd_pix_off(rd_pix_off), .frame_eof(frame_eof),
        .upd_pending(upd_pending)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Scan one frame; returns at the negedge where frame_eof should be high.
    task automatic do_frame(input logic [31:0] bu, input logic [31:0] bl,
                            input bit poke);
        int wp    = int'(cfg_words_m1) + 1;
        int np    = cfg_dual ? 2 : 1;
        int total = wp * np * (int'(cfg_lines_m1) + 1);
        logic [31:0] stride = cfg_stride;
        logic [4:0]  pix    = cfg_pix_off;
        int idx = 0;
        bit first = 1;
        bit hold_v = 0;
        logic [31:0] hold_a = 0;
        while (idx < total) begin
            @(negedge clk);
            if (first) begin
                host_we_upper = 0; host_we_lower = 0; host_validate = 0;
                check(rd_valid === 1'b1, "R9 valid after eof", {63'd0, rd_valid}, 64'd1);
                first = 0;
            end
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            rd_ready = (lfsr[1:0] != 2'b00);
            if (hold_v)
                check(rd_valid && rd_addr == hold_a, "R6 hold", {32'd0, rd_addr}, {32'd0, hold_a});
            hold_v = rd_valid && !rd_ready;
            hold_a = rd_addr;
            if (rd_valid && rd_ready) begin
                int w = idx % wp;
                int p = (idx / wp) % np;
                int l = idx / (wp * np);
                logic [31:0] ea = (p ? bl : bu) + 32'(l) * stride + 32'(4 * w);
                logic [4:0]  ep = (w == 0) ? pix : 5'd0;
                check(rd_addr == ea, "R2/R3 addr", {32'd0, rd_addr}, {32'd0, ea});
                check(rd_lower == p[0], "R4 panel", {63'd0, rd_lower}, {63'd0, p[0]});
                check(rd_line_first == (w == 0) && rd_pix_off == ep, "R5 first/pixoff",
                      {58'd0, rd_line_first, rd_pix_off}, {58'd0, (w == 0), ep});
                check(frame_eof == 1'b0, "R9 no eof mid-frame", {63'd0, frame_eof}, 64'd0);
                idx++;
                if (poke && idx == 1) begin
                    cfg_stride   = cfg_stride + 32'h10;   // R11 mid-frame change
                    cfg_pix_off  = cfg_pix_off ^ 5'd1;
                    cfg_words_m1 = cfg_words_m1 ^ 16'd1;
                end
            end
        end
        @(negedge clk);
        check(frame_eof === 1'b1, "R9 eof pulse", {63'd0, frame_eof}, 64'd1);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cfg_dual = 0; cfg_words_m1 = 1; cfg_lines_m1 = 1;
        cfg_stride = 32'h40; cfg_pix_off = 5'd3;
        rst_n = 0;
        repeat (3) @(negedge clk);
        check(rd_valid == 0 && frame_eof == 0 && upd_pending == 0, "R1 reset",
              {61'd0, rd_valid, frame_eof, upd_pending}, 64'd0);
        rst_n = 1;
        check(rd_valid == 0 && frame_eof == 0 && upd_pending == 0, "R1 post-reset",
              {61'd0, rd_valid, frame_eof, upd_pending}, 64'd0);
        do_frame(32'h0, 32'h0, 0);

        // R7: unvalidated shadow writes
        host_we_upper = 1; host_upper_base = 32'h1000;
        host_we_lower = 1; host_lower_base = 32'h2000;
        cfg_dual = 1;
        do_frame(32'h0, 32'h0, 0);
        do_frame(32'h0, 32'h0, 0);
        check(upd_pending == 0, "R7 no pending", {63'd0, upd_pending}, 64'd0);

        // R10: validate in commit cycle with nothing pending -> not used yet
        host_validate = 1;
        do_frame(32'h0, 32'h0, 0);
        check(upd_pending == 1, "R10 pending kept", {63'd0, upd_pending}, 64'd1);
        // R8: commit at this eof
        do_frame(32'h1000, 32'h2000, 0);
        check(upd_pending == 0, "R8 pending cleared", {63'd0, upd_pending}, 64'd0);

        // R10: pending already set, new write+validate in commit cycle
        host_we_upper = 1; host_upper_base = 32'h3000;
        host_we_lower = 1; host_lower_base = 32'h4000;
        host_validate = 1;
        do_frame(32'h1000, 32'h2000, 0);
        host_we_upper = 1; host_upper_base = 32'h5000;
        host_we_lower = 1; host_lower_base = 32'h6000;
        host_validate = 1;
        do_frame(32'h3000, 32'h4000, 0);
        check(upd_pending == 1, "R10 second validate pending", {63'd0, upd_pending}, 64'd1);
        do_frame(32'h5000, 32'h6000, 0);
        check(upd_pending == 0, "R8 pending cleared again", {63'd0, upd_pending}, 64'd0);

        // R11 and geometry sweep
        for (int d = 0; d < 2; d++)
            for (int l = 0; l < 3; l++)
                for (int w = 0; w < 3; w++) begin
                    cfg_dual     = d[0];
                    cfg_lines_m1 = 16'(l);
                    cfg_words_m1 = 16'(w);
                    cfg_stride   = 32'h100 + 32'(w * 32'h20);
                    cfg_pix_off  = 5'(w + 7 * l + d);
                    do_frame(32'h5000, 32'h6000, (w == 1));
                end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule